// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Interface

This block is the processor-facing register file of a two-channel asynchronous serial controller. A byte-wide bus with two selects reaches it. `bus_chan` picks the channel (1 = channel A, 0 = channel B). `bus_data` picks the data port (1) or the control port (0). Control registers are reached indirectly. A control write made while a channel's pointer is zero selects the next register, and may also carry a command. The access that follows then reads or writes the selected register, and the pointer drops back to zero.

The serializer is not part of the block. A data write finishes at once and presents the byte on a one-cycle transmit strobe. After `TX_HOLD` cycles, which stand for the time taken to send it, the transmit-pending flag rises again. Received bytes arrive on per-channel valid inputs, and break events arrive on per-channel pulses. The block keeps receive and transmit pending and in-service flags for each channel. It builds an interrupt vector whose code depends on a status-high/status-low mode, and it drives a single interrupt line shared by both channels.

Top module: `dual_sio_regs`

## Requirements
- R1: A control write made while the channel pointer is 0 loads the pointer from bits 2:0, plus 8 when bits 5:3 are 001. Any other control write, and every control read, returns that channel's pointer to 0.
- R2: After `rst_n` is released, both channels read 0x44 from register 0 and 0x07 from register 1. Registers 3, 12 and 13 read 0x00, the vector reads 0x06 and `irq` is 0. The internal reset values are: register 4 = 0x04, register 11 = 0x08, register 14 = 0x30 and register 15 = 0xF8, so break interrupts are enabled.
- R3: A write to control register 9 with bits 7:6 nonzero is a reset command: 01 resets channel B, 10 resets channel A and 11 resets both. Each reset gives the R2 state and clears status-high mode. The pointer of the channel that was written is left unchanged unless that channel is itself reset.
- R4: A data write sets register 0 bit 2 and register 1 bit 0. It also clears transmit pending, and transmit pending is set again `TX_HOLD` cycles later. On the cycle after the write, `tx_stb` pulses with `tx_byte` and `tx_chan`, but only if register 5 bit 3 is set.
- R5: A received byte is taken only when register 3 bit 0 is set and register 0 bit 0 is clear. Taking it sets register 0 bit 0, receive pending and receive in-service. Any other byte is dropped, and the held byte is kept.
- R6: A data read returns the held byte and clears register 0 bit 0, receive pending and receive in-service. If transmit is pending at that point, the transmit in-service flag is taken.
- R7: `irq` is the OR over both channels of three terms: register 1 bit 1 AND transmit pending; register 1 bits 4:3 equal to 01 or 10 AND receive pending; register 15 bit 7 AND register 0 bit 7.
- R8: Channel B register 2 reads the vector, chosen in this priority: receive A, transmit A, receive B, transmit B, none. In status-low mode the codes are 0x0C, 0x08, 0x04, 0x00 and 0x06. In status-high mode (register 9 bit 4) they are 0x30, 0x10, 0x20, 0x00 and 0x60.
- R9: Channel A register 3 reads bit 5 = receive A, bit 4 = transmit A, bit 2 = receive B and bit 1 = transmit B; bits 3 and 0 read 0. A transmit bit is set only if register 1 bit 1 is set when transmit service is taken. Channel B register 3 reads 0x00.
- R10: Control command 101 (bits 5:3 of a pointer-0 write) clears transmit pending, transmit in-service and the transmit bit of register 3. If receive is pending, receive in-service is set again.
- R11: Control command 111 clears receive in-service if it is set, and otherwise clears transmit in-service. When receive in-service is cleared while transmit is pending, transmit in-service is taken.
- R12: Transmit in-service is never taken while receive in-service is set.
- R13: Registers 12 and 13 read back the values written to them. Channel A register 2 reads the value written to channel A register 2. Registers that have no read function read 0x00.
- R14: A `rx_break` pulse sets register 0 bit 7. The bit stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_data | input | 1 | 1 = data port, 0 = control port |
| bus_chan | input | 1 | 1 = channel A, 0 = channel B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, 0 otherwise |
| rx_valid | input | 2 | Received byte present; bit 1 = A, bit 0 = B |
| rx_data_a | input | 8 | Received byte, channel A |
| rx_data_b | input | 8 | Received byte, channel B |
| rx_break | input | 2 | Break detected; bit 1 = A, bit 0 = B |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_chan | output | 1 | Channel of the strobed byte |
| tx_byte | output | 8 | Strobed byte |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench sets `TX_HOLD` to 3. This makes the interval in which transmit pending is low after a data write short enough to check cycle by cycle, while still long enough to tell apart from an immediate re-raise. Within that interval a receive can be placed in service ahead of the transmit completion, which exercises the masking rule. The default value of 4 differs only in the length of that interval.

// File: rtl/dual_sio_regs.sv
module dual_sio_regs #(
  parameter int TX_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_data,
  input  logic       bus_chan,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] rx_valid,
  input  logic [7:0] rx_data_a,
  input  logic [7:0] rx_data_b,
  input  logic [1:0] rx_break,
  output logic       tx_stb,
  output logic       tx_chan,
  output logic [7:0] tx_byte,
  output logic       irq
);

  localparam int HOLD_I = (TX_HOLD < 1) ? 1 : TX_HOLD;
  localparam int CW = (HOLD_I < 2) ? 1 : $clog2(HOLD_I + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_I);
  localparam logic [7:0] ST_INIT = 8'h44;
  localparam logic [7:0] SP_INIT = 8'h07;

  logic [7:0]    wr_q  [2][16];
  logic [7:0]    wr_n  [2][16];
  logic [3:0]    ptr_q [2];
  logic [3:0]    ptr_n [2];
  logic [7:0]    st_q  [2];
  logic [7:0]    st_n  [2];
  logic [7:0]    sp_q  [2];
  logic [7:0]    sp_n  [2];
  logic [7:0]    rxb_q [2];
  logic [7:0]    rxb_n [2];
  logic [CW-1:0] cnt_q [2];
  logic [CW-1:0] cnt_n [2];
  logic [1:0] rxp_q, rxp_n, txp_q, txp_n, rxs_q, rxs_n, txs_q, txs_n;
  logic [1:0] iprx_q, iprx_n, iptx_q, iptx_n, chres;
  logic       sthi_q, sthi_n;
  logic       tstb_n, tchan_n;
  logic [7:0] tbyte_n;
  logic [3:0] cur_ptr;
  logic [7:0] vec, ipbyte, rd_mux;
  logic [1:0] ch_irq;

  function automatic logic [7:0] wr_init(input int r);
    case (r)
      4:       wr_init = 8'h04;
      9:       wr_init = 8'hC0;
      11:      wr_init = 8'h08;
      14:      wr_init = 8'h30;
      15:      wr_init = 8'hF8;
      default: wr_init = 8'h00;
    endcase
  endfunction

  // returns {tx pending, tx in-service, tx ip bit}
  function automatic logic [2:0] tx_up(input logic rxs, input logic txs,
                                       input logic ipt, input logic ien);
    tx_up = rxs ? {1'b1, txs, ipt} : {1'b1, 1'b1, ipt | ien};
  endfunction

  assign cur_ptr = ptr_q[bus_chan];

  always_comb begin
    wr_n = wr_q; ptr_n = ptr_q; st_n = st_q; sp_n = sp_q;
    rxb_n = rxb_q; cnt_n = cnt_q; sthi_n = sthi_q;
    rxp_n = rxp_q; txp_n = txp_q; rxs_n = rxs_q; txs_n = txs_q;
    iprx_n = iprx_q; iptx_n = iptx_q;
    tstb_n = 1'b0; tchan_n = tx_chan; tbyte_n = tx_byte;
    chres = 2'b00;

    for (int c = 0; c < 2; c++) begin
      if (rx_break[c]) st_n[c][7] = 1'b1;
      if (rx_valid[c] && wr_q[c][3][0] && !st_q[c][0]) begin
        st_n[c][0] = 1'b1;
        rxb_n[c]   = (c == 1) ? rx_data_a : rx_data_b;
        rxp_n[c]   = 1'b1;
        rxs_n[c]   = 1'b1;
        iprx_n[c]  = 1'b1;
      end
      if (cnt_q[c] != '0) begin
        cnt_n[c] = cnt_q[c] - CW'(1);
        if (cnt_q[c] == CW'(1))
          {txp_n[c], txs_n[c], iptx_n[c]} =
            tx_up(rxs_n[c], txs_n[c], iptx_n[c], wr_q[c][1][1]);
      end
    end

    if (bus_wr && !bus_data) begin
      if (cur_ptr == 4'd0) begin
        ptr_n[bus_chan] = {bus_wdata[5:3] == 3'b001, bus_wdata[2:0]};
        if (bus_wdata[5:3] == 3'b101) begin
          txp_n[bus_chan]  = 1'b0;
          txs_n[bus_chan]  = 1'b0;
          iptx_n[bus_chan] = 1'b0;
          if (rxp_n[bus_chan]) begin
            rxs_n[bus_chan]  = 1'b1;
            iprx_n[bus_chan] = 1'b1;
          end
        end else if (bus_wdata[5:3] == 3'b111) begin
          if (rxs_n[bus_chan]) begin
            rxs_n[bus_chan] = 1'b0;
            if (txp_n[bus_chan])
              {txp_n[bus_chan], txs_n[bus_chan], iptx_n[bus_chan]} =
                tx_up(1'b0, txs_n[bus_chan], iptx_n[bus_chan], wr_q[bus_chan][1][1]);
          end else begin
            txs_n[bus_chan] = 1'b0;
          end
        end
      end else if (cur_ptr == 4'd9) begin
        if (bus_wdata[7:6] == 2'b00) begin
          sthi_n = bus_wdata[4];
          ptr_n[bus_chan] = 4'd0;
        end else begin
          chres = {bus_wdata[7], bus_wdata[6]};
        end
      end else begin
        wr_n[bus_chan][cur_ptr] = bus_wdata;
        ptr_n[bus_chan] = 4'd0;
      end
    end

    if (bus_wr && bus_data) begin
      txp_n[bus_chan]   = 1'b0;
      cnt_n[bus_chan]   = HOLD;
      tstb_n            = wr_q[bus_chan][5][3];
      tchan_n           = bus_chan;
      tbyte_n           = bus_wdata;
      st_n[bus_chan][2] = 1'b1;
      sp_n[bus_chan][0] = 1'b1;
    end

    if (bus_rd && !bus_data) ptr_n[bus_chan] = 4'd0;

    if (bus_rd && bus_data) begin
      st_n[bus_chan][0] = 1'b0;
      rxp_n[bus_chan]   = 1'b0;
      rxs_n[bus_chan]   = 1'b0;
      iprx_n[bus_chan]  = 1'b0;
      if (txp_n[bus_chan])
        {txp_n[bus_chan], txs_n[bus_chan], iptx_n[bus_chan]} =
          tx_up(1'b0, txs_n[bus_chan], iptx_n[bus_chan], wr_q[bus_chan][1][1]);
    end

    for (int c = 0; c < 2; c++) begin
      if (chres[c]) begin
        for (int r = 0; r < 16; r++) wr_n[c][r] = wr_init(r);
        ptr_n[c] = 4'd0; st_n[c] = ST_INIT; sp_n[c] = SP_INIT;
        rxb_n[c] = 8'h00; cnt_n[c] = '0;
        rxp_n[c] = 1'b0; txp_n[c] = 1'b0; rxs_n[c] = 1'b0; txs_n[c] = 1'b0;
        iprx_n[c] = 1'b0; iptx_n[c] = 1'b0;
        sthi_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 16; r++) wr_q[c][r] <= wr_init(r);
        ptr_q[c] <= 4'd0; st_q[c] <= ST_INIT; sp_q[c] <= SP_INIT;
        rxb_q[c] <= 8'h00; cnt_q[c] <= '0;
      end
      rxp_q <= '0; txp_q <= '0; rxs_q <= '0; txs_q <= '0;
      iprx_q <= '0; iptx_q <= '0; sthi_q <= 1'b0;
      tx_stb <= 1'b0; tx_chan <= 1'b0; tx_byte <= 8'h00;
    end else begin
      wr_q <= wr_n; ptr_q <= ptr_n; st_q <= st_n; sp_q <= sp_n;
      rxb_q <= rxb_n; cnt_q <= cnt_n; sthi_q <= sthi_n;
      rxp_q <= rxp_n; txp_q <= txp_n; rxs_q <= rxs_n; txs_q <= txs_n;
      iprx_q <= iprx_n; iptx_q <= iptx_n;
      tx_stb <= tstb_n; tx_chan <= tchan_n; tx_byte <= tbyte_n;
    end
  end

  always_comb begin
    if (rxs_q[1])      vec = sthi_q ? 8'h30 : 8'h0C;
    else if (txs_q[1]) vec = sthi_q ? 8'h10 : 8'h08;
    else if (rxs_q[0]) vec = sthi_q ? 8'h20 : 8'h04;
    else if (txs_q[0]) vec = 8'h00;
    else               vec = sthi_q ? 8'h60 : 8'h06;
  end

  assign ipbyte = {2'b00, iprx_q[1], iptx_q[1], 1'b0, iprx_q[0], iptx_q[0], 1'b0};

  always_comb begin
    if (bus_data) rd_mux = rxb_q[bus_chan];
    else begin
      case (cur_ptr)
        4'd0:    rd_mux = st_q[bus_chan];
        4'd1:    rd_mux = sp_q[bus_chan];
        4'd2:    rd_mux = bus_chan ? wr_q[1][2] : vec;
        4'd3:    rd_mux = bus_chan ? ipbyte : 8'h00;
        4'd12:   rd_mux = wr_q[bus_chan][12];
        4'd13:   rd_mux = wr_q[bus_chan][13];
        default: rd_mux = 8'h00;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : 8'h00;

  for (genvar g = 0; g < 2; g++) begin : g_irq
    assign ch_irq[g] = (wr_q[g][1][1] & txp_q[g]) |
                       (((wr_q[g][1][4:3] == 2'b01) || (wr_q[g][1][4:3] == 2'b10)) & rxp_q[g]) |
                       (wr_q[g][15][7] & st_q[g][7]);
  end
  assign irq = |ch_irq;

  p_rd_ptr_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_data && !bus_chan) |=> (ptr_q[0] == 4'd0));
  p_rd_ptr_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_data && bus_chan) |=> (ptr_q[1] == 4'd0));
  p_rst_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_data && cur_ptr == 4'd9 && bus_wdata[7:6] == 2'b11)
    |=> (st_q[0] == ST_INIT && st_q[1] == ST_INIT && !irq));
  p_tx_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_data) |=> (tx_stb == $past(wr_q[bus_chan][5][3])));
  p_tx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_data) |=> !tx_stb);
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_data && bus_chan) |=> !txp_q[1]);
  p_rx_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid[0] && st_q[0][0] && !bus_wr && !bus_rd) |=> $stable(rxb_q[0]));
  p_tx_svc_a_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txs_q[1]) |-> !rxs_q[1]);
  p_tx_svc_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txs_q[0]) |-> !rxs_q[0]);

endmodule

// File: tb/sim_dual_sio_regs.sv
module sim_dual_sio_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_data = 1'b0, bus_chan = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] rx_valid = 2'b00, rx_break = 2'b00;
  logic [7:0] rx_data_a = 8'h00, rx_data_b = 8'h00;
  logic tx_stb, tx_chan, irq;
  logic [7:0] tx_byte;
  int checks = 0, errors = 0;
  logic [7:0] shadow [2][2];

  dual_sio_regs #(.TX_HOLD(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_data(bus_data), .bus_chan(bus_chan), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data_a(rx_data_a),
    .rx_data_b(rx_data_b), .rx_break(rx_break), .tx_stb(tx_stb),
    .tx_chan(tx_chan), .tx_byte(tx_byte), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic hi, input logic rsa, input logic tsa,
                                         input logic rsb, input logic tsb);
    if (rsa)      return hi ? 8'h30 : 8'h0C;
    else if (tsa) return hi ? 8'h10 : 8'h08;
    else if (rsb) return hi ? 8'h20 : 8'h04;
    else if (tsb) return 8'h00;
    else          return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [7:0] exp_rr3(input logic ra, input logic ta, input logic rb, input logic tb);
    return {2'b00, ra, ta, 1'b0, rb, tb, 1'b0};
  endfunction

  function automatic logic exp_irq(input logic [7:0] w1, input logic txp, input logic rxp,
                                   input logic [7:0] w15, input logic brk);
    return (w1[1] & txp) | (((w1[4:3] == 2'b01) || (w1[4:3] == 2'b10)) & rxp) | (w15[7] & brk);
  endfunction

  function automatic logic [7:0] ptr_byte(input int r);
    return (r < 8) ? 8'(r) : (8'h08 | 8'(r & 7));
  endfunction

  task automatic bw(input logic ch, input logic dsel, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_chan = ch; bus_data = dsel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic ch, input logic dsel, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_chan = ch; bus_data = dsel;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wreg(input logic ch, input int r, input logic [7:0] v);
    if (r != 0) bw(ch, 1'b0, ptr_byte(r));
    bw(ch, 1'b0, v);
  endtask

  task automatic rreg(input logic ch, input int r, output logic [7:0] v);
    if (r != 0) bw(ch, 1'b0, ptr_byte(r));
    br(ch, 1'b0, v);
  endtask

  task automatic rxin(input logic ch, input logic [7:0] b);
    @(negedge clk);
    rx_valid[ch] = 1'b1;
    if (ch) rx_data_a = b; else rx_data_b = b;
    @(negedge clk);
    rx_valid = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, w, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rreg(0, 0, v); chk("R2 B rr0", v, 8'h44);
    rreg(1, 0, v); chk("R2 A rr0", v, 8'h44);
    rreg(0, 1, v); chk("R2 B rr1", v, 8'h07);
    rreg(1, 1, v); chk("R2 A rr1", v, 8'h07);
    rreg(0, 2, v); chk("R2 vector", v, exp_vec(0, 0, 0, 0, 0));
    rreg(1, 3, v); chk("R2 rr3", v, 8'h00);
    rreg(0, 12, v); chk("R2 rr12", v, 8'h00);
    chk("R2 irq", {7'b0, irq}, 8'h00);

    // R1 pointer with point-high, R13 mirrors
    bw(0, 0, 8'h0C); bw(0, 0, 8'h5A);
    rreg(0, 12, v); chk("R1 point-high write", v, 8'h5A);
    bw(1, 0, 8'h0D); bw(1, 0, 8'hA5);
    rreg(1, 13, v); chk("R13 rr13 mirror", v, 8'hA5);
    bw(0, 0, 8'h0C);
    br(0, 0, v); chk("R1 read at ptr 12", v, 8'h5A);
    br(0, 0, v); chk("R1 ptr back to 0", v, 8'h44);
    wreg(1, 2, 8'h77);
    rreg(1, 2, v); chk("R13 A rr2 raw", v, 8'h77);
    rreg(1, 10, v); chk("R13 unmapped reads 0", v, 8'h00);
    shadow[0][0] = 8'h5A; shadow[0][1] = 8'h00;
    shadow[1][0] = 8'h00; shadow[1][1] = 8'hA5;
    for (int i = 0; i < 12; i++) begin
      int ch, r;
      ch = int'($urandom % 2); r = int'($urandom % 2);
      w = 8'($urandom);
      wreg(ch[0], 12 + r, w);
      shadow[ch][r] = w;
      rreg(ch[0], 12 + r, v); chk("R13 random mirror", v, shadow[ch][r]);
    end

    // R5 R7 R8 R9 receive
    wreg(0, 3, 8'h01);
    rxin(0, 8'h31);
    rreg(0, 0, v); chk("R5 rx available", v, 8'h45);
    rreg(0, 2, v); chk("R8 vector rx B", v, exp_vec(0, 0, 0, 1, 0));
    rreg(1, 3, v); chk("R9 rr3 rx B", v, exp_rr3(0, 0, 1, 0));
    rreg(0, 3, v); chk("R9 B rr3 zero", v, 8'h00);
    w = 8'h00;
    for (int i = 0; i < 8; i++) begin
      w = 8'($urandom) & 8'h1A;
      wreg(0, 1, w);
      chk("R7 irq rx mode", {7'b0, irq}, {7'b0, exp_irq(w, 0, 1, 8'h00, 0)});
    end
    rxin(0, 8'h99);
    br(0, 1, v); chk("R5 second byte dropped", v, 8'h31);
    rreg(0, 0, v); chk("R6 rx available cleared", v, 8'h44);
    rreg(0, 2, v); chk("R6 vector after read", v, exp_vec(0, 0, 0, 0, 0));
    chk("R7 irq after read", {7'b0, irq}, 8'h00);
    rxin(1, 8'h55);
    rreg(1, 0, v); chk("R5 rx disabled", v, 8'h44);
    wreg(1, 3, 8'h01);
    for (int i = 0; i < 10; i++) begin
      logic ch;
      ch = 1'($urandom);
      b = 8'($urandom);
      rxin(ch, b);
      br(ch, 1, v); chk("R6 random rx byte", v, b);
    end

    // R4 transmit
    wreg(1, 1, 8'h02);
    wreg(1, 5, 8'h08);
    bw(1, 1, 8'h3C);
    chk("R4 tx_stb", {7'b0, tx_stb}, 8'h01);
    chk("R4 tx_byte", tx_byte, 8'h3C);
    chk("R4 tx_chan", {7'b0, tx_chan}, 8'h01);
    chk("R4 irq low at write", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 tx_stb one cycle", {7'b0, tx_stb}, 8'h00);
    chk("R4 hold cycle 2", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 hold cycle 3", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 tx pending raised", {7'b0, irq}, 8'h01);
    rreg(1, 1, v); chk("R4 all-sent", v, 8'h07);
    rreg(1, 0, v); chk("R4 tx empty", v, 8'h44);
    rreg(0, 2, v); chk("R8 vector tx A", v, exp_vec(0, 0, 1, 0, 0));
    rreg(1, 3, v); chk("R9 rr3 tx A", v, exp_rr3(0, 1, 0, 0));
    wreg(1, 5, 8'h00);
    bw(1, 1, 8'h11);
    chk("R4 no strobe when disabled", {7'b0, tx_stb}, 8'h00);
    repeat (4) @(negedge clk);

    // R10 clear tx
    bw(1, 0, 8'h28);
    chk("R10 irq cleared", {7'b0, irq}, 8'h00);
    rreg(0, 2, v); chk("R10 vector none", v, exp_vec(0, 0, 0, 0, 0));
    rreg(1, 3, v); chk("R10 rr3 cleared", v, 8'h00);

    // R12 R11 in-service ordering, R8 status-high
    wreg(1, 1, 8'h12);
    rxin(1, 8'hC3);
    rreg(0, 2, v); chk("R8 vector rx A", v, exp_vec(0, 1, 0, 0, 0));
    chk("R7 irq rx A", {7'b0, irq}, 8'h01);
    bw(1, 1, 8'h44);
    repeat (4) @(negedge clk);
    rreg(0, 2, v); chk("R12 tx masked by rx svc", v, exp_vec(0, 1, 0, 0, 0));
    rreg(1, 3, v); chk("R12 rr3 no tx bit", v, exp_rr3(1, 0, 0, 0));
    bw(1, 0, 8'h38);
    rreg(0, 2, v); chk("R11 tx svc taken", v, exp_vec(0, 0, 1, 0, 0));
    rreg(1, 3, v); chk("R11 rr3 tx bit", v, exp_rr3(1, 1, 0, 0));
    wreg(0, 9, 8'h10);
    rreg(0, 2, v); chk("R8 status-high tx A", v, exp_vec(1, 0, 1, 0, 0));
    bw(1, 0, 8'h38);
    rreg(0, 2, v); chk("R11 tx svc cleared", v, exp_vec(1, 0, 0, 0, 0));
    br(1, 1, v); chk("R6 read rx A", v, 8'hC3);
    rreg(0, 2, v); chk("R6 tx svc after read", v, exp_vec(1, 0, 1, 0, 0));
    bw(1, 0, 8'h28);
    rreg(0, 2, v); chk("R10 vector none high", v, exp_vec(1, 0, 0, 0, 0));

    // R3 reset commands
    bw(1, 0, 8'h09); bw(1, 0, 8'h40);
    br(1, 0, v); chk("R3 writer ptr kept", v, 8'h00);
    br(1, 0, v); chk("R3 A rr0 after", v, 8'h44);
    rreg(0, 12, v); chk("R3 B reset rr12", v, 8'h00);
    rreg(1, 12, v); chk("R3 A untouched", v, shadow[1][0]);
    rreg(0, 2, v); chk("R3 status-high cleared", v, exp_vec(0, 0, 0, 0, 0));
    wreg(0, 12, 8'h6E);
    bw(0, 0, 8'h09); bw(0, 0, 8'h80);
    br(0, 0, v); chk("R3 B ptr kept", v, 8'h00);
    rreg(1, 12, v); chk("R3 A reset rr12", v, 8'h00);
    rreg(1, 2, v); chk("R3 A wr2 reset", v, 8'h00);
    rreg(0, 12, v); chk("R3 B untouched", v, 8'h6E);

    // R14 break
    @(negedge clk); rx_break = 2'b01; @(negedge clk); rx_break = 2'b00;
    chk("R14 break irq", {7'b0, irq}, 8'h01);
    rreg(0, 0, v); chk("R14 break status", v, 8'hC4);
    wreg(0, 15, 8'h00);
    chk("R7 break irq masked", {7'b0, irq}, 8'h00);
    rreg(0, 0, v); chk("R14 break sticky", v, 8'hC4);
    bw(0, 0, 8'h09); bw(0, 0, 8'hC0);
    rreg(0, 0, v); chk("R3 both reset rr0", v, 8'h44);
    rreg(0, 1, v); chk("R2 rr1 after cmd", v, 8'h07);
    rreg(0, 12, v); chk("R3 both reset B12", v, 8'h00);
    chk("R3 irq after reset", {7'b0, irq}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule